// File: doc/BRIEF.md
# Dual Sprite Pixel Shifter

This block merges two paired sprites into one packed pixel stream. Each sprite has a 16-bit low-plane word and a 16-bit high-plane word. Together they give sixteen 2-bit pixels for that sprite. A load places one sprite's pixels into a shared 64-bit store. Each shift strobe then advances the stream by one two-pixel step.

The 8-bit output byte always shows the head of the stream. It holds two pixels from each sprite, interleaved, ready for the pixel mixer that follows.

A load can hold back its sprite by one pixel. The last pixel, pushed past the end of the store, waits in an 8-bit spill register. It rejoins the stream on the next shift.

Top module: `dual_sprite_shifter`

## Requirements
- R1: A synchronous active-high reset clears the store and the spill register. The output reads 8'h00, and a shift right after reset still gives 8'h00.
- R2: Pixel i (0 to 15) of a loaded sprite is {hi_word_i[15-i], lo_word_i[15-i]}. Pixel 0 leads the stream.
- R3: Output layout. Bits 7:6 are sprite 0's first pixel and bits 5:4 are sprite 1's first pixel. Bits 3:2 are sprite 0's second pixel and bits 1:0 are sprite 1's second pixel.
- R4: Each shift_i pulse advances the stream by two pixels per sprite. The output shows the new head one clock after the pulse.
- R5: With delay_i = 1, every pixel of the loaded sprite lands one position later than with delay_i = 0. Its pixel 15 sits in the spill register and reaches the head after eight shifts.
- R6: A load touches only the selected sprite's fields (load_sel_i = 0 picks sprite 0, 1 picks sprite 1). The other sprite's pixels are unchanged.
- R7: When load and shift occur in the same cycle, the shift is applied first. The new pixels are then merged at the head of the shifted stream.
- R8: With neither strobe asserted, the store and the output hold their value.
- R9: A shift merges the spill register into the vacated low byte and clears the spill register. A later shift brings in zeros.
- R10: A load ORs its bits into the store. Bits already set stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe |
| load_sel_i | input | 1 | Sprite picked by the load (0 or 1) |
| lo_word_i | input | 16 | Low-plane pixel bits, MSB first |
| hi_word_i | input | 16 | High-plane pixel bits, MSB first |
| delay_i | input | 1 | Hold the loaded sprite back one pixel |
| shift_i | input | 1 | Advance the stream by two pixels |
| pix_o | output | 8 | Head of the stream, four 2-bit fields |

## Verification
Several properties are checked on every cycle:
- the head advances on a plain shift and the spill register drains;
- the store is stable when idle;
- a load of sprite 0 leaves sprite 1's fields alone;
- a load only sets bits and never clears them;
- reset leaves everything zero.

Other behaviours are visible only through the bench's scenarios, compared cycle by cycle against a pixel-queue model:
- the exact pixel encoding and field layout;
- the one-pixel delay;
- the spilled pixel arriving after eight shifts;
- the ordering of a load and a shift in the same cycle.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int FIELD_W  = 2;                    // bits per sprite pixel
  localparam int SPRITES  = 2;                    // sprites sharing the store
  localparam int PIX_SPAN = FIELD_W * SPRITES;    // bits per pixel position
  localparam int STEP_PIX = 2;                    // pixels per shift
  localparam int STEP_W   = PIX_SPAN * STEP_PIX;  // bits per shift
endpackage

// File: rtl/sps_spread.sv
module sps_spread
  import sps_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int STORE_W = WORD_W * PIX_SPAN
) (
  input  logic [WORD_W-1:0]  lo_word,
  input  logic [WORD_W-1:0]  hi_word,
  input  logic               sel,
  input  logic               dly,
  output logic [STORE_W-1:0] store_bits,
  output logic [STEP_W-1:0]  spill_bits
);
  logic [STORE_W-1:0]        base0;
  logic [STORE_W-1:0]        placed;
  logic [STORE_W+STEP_W-1:0] wide;

  // Sprite 0 positions: pixel i goes to slot i, each slot PIX_SPAN bits wide.
  always_comb begin
    base0 = '0;
    for (int i = 0; i < WORD_W; i++) begin
      base0[STORE_W-1 - PIX_SPAN*i -: FIELD_W] = {hi_word[WORD_W-1-i], lo_word[WORD_W-1-i]};
    end
  end

  // Sprite 1 fields lie one field below sprite 0's.
  assign placed = sel ? (base0 >> FIELD_W) : base0;

  // A delay moves the whole sprite one pixel slot later; the tail spills.
  assign wide = dly ? ({placed, {STEP_W{1'b0}}} >> PIX_SPAN)
                    : {placed, {STEP_W{1'b0}}};

  assign store_bits = wide[STORE_W+STEP_W-1:STEP_W];
  assign spill_bits = wide[STEP_W-1:0];
endmodule

// File: rtl/sps_store.sv
module sps_store
  import sps_pkg::*;
#(
  parameter int STORE_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               shift,
  input  logic [STORE_W-1:0] ld_store,
  input  logic [STEP_W-1:0]  ld_spill,
  output logic [STORE_W-1:0] store_q,
  output logic [STEP_W-1:0]  spill_q
);
  logic [STORE_W-1:0] shifted;
  logic [STEP_W-1:0]  spill_kept;
  logic [STORE_W-1:0] store_d;
  logic [STEP_W-1:0]  spill_d;

  // Shift first; the spill byte fills the vacated low end and is consumed.
  assign shifted    = shift ? {store_q[STORE_W-STEP_W-1:0], spill_q} : store_q;
  assign spill_kept = shift ? '0 : spill_q;

  // Then OR any new sprite bits in.
  assign store_d = shifted    | (load ? ld_store : '0);
  assign spill_d = spill_kept | (load ? ld_spill : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      spill_q <= '0;
    end else begin
      store_q <= store_d;
      spill_q <= spill_d;
    end
  end
endmodule

// File: rtl/dual_sprite_shifter.sv
module dual_sprite_shifter
  import sps_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              load_sel_i,
  input  logic [WORD_W-1:0] lo_word_i,
  input  logic [WORD_W-1:0] hi_word_i,
  input  logic              delay_i,
  input  logic              shift_i,
  output logic [STEP_W-1:0] pix_o
);
  localparam int STORE_W = WORD_W * PIX_SPAN;

  logic [STORE_W-1:0] ld_store;
  logic [STEP_W-1:0]  ld_spill;
  logic [STORE_W-1:0] store_q;
  logic [STEP_W-1:0]  spill_q;

  sps_spread #(.WORD_W(WORD_W)) u_spread (
    .lo_word    (lo_word_i),
    .hi_word    (hi_word_i),
    .sel        (load_sel_i),
    .dly        (delay_i),
    .store_bits (ld_store),
    .spill_bits (ld_spill)
  );

  sps_store #(.STORE_W(STORE_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .shift    (shift_i),
    .ld_store (ld_store),
    .ld_spill (ld_spill),
    .store_q  (store_q),
    .spill_q  (spill_q)
  );

  // The head byte is a slice of the register itself.
  assign pix_o = store_q[STORE_W-1 -: STEP_W];
endmodule

// File: rtl/sps_check.sv
module sps_check
  import sps_pkg::*;
#(
  parameter int STORE_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               load_i,
  input logic               load_sel_i,
  input logic               shift_i,
  input logic [STEP_W-1:0]  pix_o,
  input logic [STORE_W-1:0] store_q,
  input logic [STEP_W-1:0]  spill_q
);
  localparam logic [STORE_W-1:0] S1_MASK = {(STORE_W/STEP_W){8'h33}};

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (store_q == '0 && spill_q == '0 && pix_o == '0));

  assert_head_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i) |=> pix_o == $past(store_q[STORE_W-STEP_W-1 -: STEP_W]));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!shift_i && !load_i) |=> ($stable(store_q) && $stable(spill_q)));

  assert_spill_drained_R9: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i) |=> spill_q == '0);

  assert_other_sprite_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (load_i && !shift_i && !load_sel_i) |=> (store_q & S1_MASK) == $past(store_q & S1_MASK));

  assert_or_merge_R10: assert property (@(posedge clk) disable iff (rst)
    (load_i && !shift_i) |=> (store_q & $past(store_q)) == $past(store_q));
endmodule

bind dual_sprite_shifter sps_check #(.STORE_W(STORE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_i     (load_i),
  .load_sel_i (load_sel_i),
  .shift_i    (shift_i),
  .pix_o      (pix_o),
  .store_q    (store_q),
  .spill_q    (spill_q)
);

// File: tb/dual_sprite_shifter_test.sv
`timescale 1ns/1ps
module dual_sprite_shifter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0, load_sel_i = 1'b0, delay_i = 1'b0, shift_i = 1'b0;
  logic [15:0] lo_word_i = '0, hi_word_i = '0;
  logic [7:0]  pix_o;

  int    n_run = 0, n_fail = 0;
  bit    live  = 1'b0;
  string cur_req = "R1";

  // Reference: one queue of 2-bit pixels per sprite, position 0 = head.
  logic [1:0] q0 [0:17];
  logic [1:0] q1 [0:17];

  always #2 clk = ~clk;  // 250 MHz

  dual_sprite_shifter uut (
    .clk(clk), .rst(rst), .load_i(load_i), .load_sel_i(load_sel_i),
    .lo_word_i(lo_word_i), .hi_word_i(hi_word_i), .delay_i(delay_i),
    .shift_i(shift_i), .pix_o(pix_o)
  );

  function automatic logic [7:0] model_head();
    return {q0[0], q1[0], q0[1], q1[1]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 18; k++) begin q0[k] = 2'b00; q1[k] = 2'b00; end
    end else begin
      if (shift_i) begin
        for (int k = 0; k < 16; k++) begin q0[k] = q0[k+2]; q1[k] = q1[k+2]; end
        q0[16] = 2'b00; q0[17] = 2'b00; q1[16] = 2'b00; q1[17] = 2'b00;
      end
      if (load_i) begin
        for (int i = 0; i < 16; i++) begin
          if (load_sel_i) q1[i + int'(delay_i)] = q1[i + int'(delay_i)] | {hi_word_i[15-i], lo_word_i[15-i]};
          else            q0[i + int'(delay_i)] = q0[i + int'(delay_i)] | {hi_word_i[15-i], lo_word_i[15-i]};
        end
      end
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (live) begin
      n_run++;
      if (pix_o !== model_head()) begin
        n_fail++;
        $display("FAIL %s model compare: actual %02h expected %02h", cur_req, pix_o, model_head());
      end
    end
  end

  task automatic check(input string req, input logic [7:0] exp);
    n_run++;
    if (pix_o !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, pix_o, exp);
    end
  endtask

  task automatic step(input bit ld, input bit sel, input logic [15:0] lo,
                      input logic [15:0] hi, input bit d, input bit sh);
    @(negedge clk);
    load_i = ld; load_sel_i = sel; lo_word_i = lo; hi_word_i = hi; delay_i = d; shift_i = sh;
    @(posedge clk); #1;
    load_i = 1'b0; shift_i = 1'b0; delay_i = 1'b0; load_sel_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); live = 1'b0; rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0; live = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    cur_req = "R1"; check("R1", 8'h00);
    step(0, 0, 16'h0, 16'h0, 0, 1); check("R1", 8'h00);

    cur_req = "R2";
    step(1, 0, 16'hFFFF, 16'h0000, 0, 0); check("R2", 8'h44);
    cur_req = "R3";
    step(1, 1, 16'h4000, 16'hC000, 0, 0); check("R3", 8'h67);
    cur_req = "R6"; check("R6", 8'h67);
    cur_req = "R4";
    step(0, 0, 16'h0, 16'h0, 0, 1); check("R4", 8'h44);

    do_reset();
    cur_req = "R5";
    step(1, 0, 16'h8000, 16'h8000, 1, 0); check("R5", 8'h0C);
    do_reset();
    step(1, 1, 16'h0001, 16'h0001, 1, 0); check("R5", 8'h00);
    for (int s = 0; s < 7; s++) begin
      step(0, 0, 16'h0, 16'h0, 0, 1); check("R5", 8'h00);
    end
    step(0, 0, 16'h0, 16'h0, 0, 1); check("R5", 8'h30);
    cur_req = "R9";
    step(0, 0, 16'h0, 16'h0, 0, 1); check("R9", 8'h00);

    do_reset();
    cur_req = "R7";
    step(1, 0, 16'hFFFF, 16'h0000, 0, 0);
    step(1, 1, 16'hFFFF, 16'hFFFF, 0, 1); check("R7", 8'h77);
    cur_req = "R8";
    for (int s = 0; s < 3; s++) begin
      step(0, 0, 16'hFFFF, 16'hFFFF, 1, 0); check("R8", 8'h77);
    end
    cur_req = "R10";
    step(1, 0, 16'h0000, 16'hFFFF, 0, 0); check("R10", 8'hFF);
    step(1, 0, 16'h0000, 16'h0000, 0, 0); check("R10", 8'hFF);

    cur_req = "R4";
    step(1, 0, 16'hA5C3, 16'h3C5A, 1, 0);
    step(1, 1, 16'h0F0F, 16'hF00F, 0, 1);
    for (int s = 0; s < 9; s++) step(0, 0, 16'h0, 16'h0, 0, 1);

    @(negedge clk); live = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule